// File: doc/BRIEF.md
# Locked-Instruction Legality Checker

This block sits beside an x86 instruction fetch path and watches the byte stream one byte per valid cycle. A `start` pulse marks an instruction boundary. If the first byte after that boundary is the LOCK prefix (0xF0), the block arms a lock flag. It then walks a set of classification tables to decide whether the instruction that follows may carry the prefix. The decode stage uses the verdict to replace a badly locked instruction with an invalid-opcode exception.

The walk has three levels. The first level classifies the primary opcode. The second level classifies the byte after the 0x0F escape. The third level is a group table chosen by the opcode and indexed by the ModRM reg field (bits 5:3). Segment-override and size-override prefixes that follow LOCK only delay the decision to the next byte. Wherever the tables allow LOCK, the operand must be in memory, so the ModRM mod field (bits 7:6) must differ from 2'b11. Once a verdict is given, the lock flag drops and the rest of the instruction is ignored.

Top module: `lock_prefix_checker`

## Requirements
- R1: After reset, `done`, `legal`, `illegal_op` and `lock_active` are all 0.
- R2: `lock_active` goes high only when the first valid byte after a `start` pulse is 0xF0. It drops in the cycle the verdict is shown, and also one cycle after any `start` pulse. If the first byte is anything else, no verdict is produced for that instruction.
- R3: A verdict is a single-cycle `done` pulse in the cycle after the deciding byte is accepted. During that pulse exactly one of `legal` and `illegal_op` is 1, and both are 0 whenever `done` is 0.
- R4: These opcodes are memory-operand opcodes: 0x00–0x37 where bits 2:0 are at most 5 and bits 5:3 are not 7, plus 0x86 and 0x87. Each is legal if and only if bits 7:6 of the next byte are not 2'b11.
- R5: Every opcode that is not a prefix, not 0x0F and not one of the group or memory-operand opcodes is illegal. This includes 0x40–0x63, 0x68–0x7F, 0x38–0x3D and a second 0xF0. The verdict follows the opcode byte itself.
- R6: Any number of the bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66 and 0x67 after LOCK are skipped, and the whole check runs on the next byte.
- R7: For opcodes 0x80–0x83, ModRM reg values 0–6 are legal with a memory operand, and reg value 7 is illegal.
- R8: For 0xF6/0xF7 only reg values 2 and 3 are legal. For 0xFE/0xFF only reg values 0 and 1 are legal. Both groups also require a memory operand.
- R9: After 0x0F, the second bytes 0xAB, 0xB3, 0xBB, 0xB0, 0xB1, 0xC0 and 0xC1 apply the memory-operand check to the third byte. Every other second byte except 0xBA is illegal, with the verdict following the second byte.
- R10: For 0x0F 0xBA, reg values 5, 6 and 7 of the third byte are legal with a memory operand. Reg values 0–4 are illegal.
- R11: Bytes presented with `byte_valid` low change nothing. A `start` pulse abandons a walk in progress without a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction boundary pulse; the byte in the same cycle is not examined |
| byte_valid | input | 1 | `byte_in` holds a stream byte this cycle |
| byte_in | input | 8 | Instruction byte |
| done | output | 1 | One-cycle verdict strobe |
| legal | output | 1 | Verdict: LOCK is allowed |
| illegal_op | output | 1 | Verdict: raise an invalid-opcode exception |
| lock_active | output | 1 | A LOCK prefix has been seen and the verdict is pending |

## Verification
Every verdict is due exactly one clock after its deciding byte. That byte is the opcode for never-legal opcodes, the second byte for rejected escapes, and otherwise the ModRM byte. The bench drives each byte on a falling edge and holds it for one cycle. It samples at the next falling edge, by which point the registering edge has passed. At every sampled byte, a reference walk in the bench gives the index of the deciding byte. The bench expects `done` only at that index and expects it low for every earlier or later byte. `lock_active` is checked at the same sample points, after the LOCK byte and after the verdict.

// File: rtl/lockchk_pkg.sv
`timescale 1ns/1ps
package lockchk_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 3;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [FIELD_W-1:0] field_t;

    localparam byte_t LOCK_BYTE = 8'hF0;
    localparam byte_t ESC_BYTE  = 8'h0F;

    typedef enum logic [2:0] {
        CLS_NEVER  = 3'd0,
        CLS_MEMOP  = 3'd1,
        CLS_ESCAPE = 3'd2,
        CLS_GROUP  = 3'd3,
        CLS_PREFIX = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        GRP_ALU,
        GRP_UNARY,
        GRP_INCDEC,
        GRP_BITTEST
    } grp_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_OPC,
        ST_ESC,
        ST_MOD,
        ST_GRP
    } walk_state_e;

    typedef struct packed {
        op_class_e cls;
        grp_kind_e kind;
    } class_info_t;

    function automatic logic is_skip_prefix(byte_t b);
        case (b)
            8'h26, 8'h2E, 8'h36, 8'h3E,
            8'h64, 8'h65, 8'h66, 8'h67: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic class_info_t primary_class(byte_t b);
        class_info_t r;
        r.cls  = CLS_NEVER;
        r.kind = GRP_ALU;
        if (b == ESC_BYTE)
            r.cls = CLS_ESCAPE;
        else if (is_skip_prefix(b))
            r.cls = CLS_PREFIX;
        else if (b[7:6] == 2'b00 && b[5:3] != 3'b111 && b[2:1] != 2'b11)
            r.cls = CLS_MEMOP;
        else if (b[7:1] == 7'b1000_011)
            r.cls = CLS_MEMOP;
        else if (b[7:2] == 6'b1000_00) begin
            r.cls  = CLS_GROUP;
            r.kind = GRP_ALU;
        end else if (b[7:1] == 7'b1111_011) begin
            r.cls  = CLS_GROUP;
            r.kind = GRP_UNARY;
        end else if (b[7:1] == 7'b1111_111) begin
            r.cls  = CLS_GROUP;
            r.kind = GRP_INCDEC;
        end
        return r;
    endfunction

    function automatic class_info_t escape_class(byte_t b);
        class_info_t r;
        r.cls  = CLS_NEVER;
        r.kind = GRP_BITTEST;
        case (b)
            8'hAB, 8'hB3, 8'hBB, 8'hB0, 8'hB1, 8'hC0, 8'hC1: r.cls = CLS_MEMOP;
            8'hBA:                                           r.cls = CLS_GROUP;
            default:                                         r.cls = CLS_NEVER;
        endcase
        return r;
    endfunction

    function automatic logic group_allows(grp_kind_e kind, field_t reg_f);
        case (kind)
            GRP_ALU:     return reg_f != 3'd7;
            GRP_UNARY:   return reg_f == 3'd2 || reg_f == 3'd3;
            GRP_INCDEC:  return reg_f == 3'd0 || reg_f == 3'd1;
            GRP_BITTEST: return reg_f[2] && reg_f[1:0] != 2'b00;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic mod_is_mem(byte_t b);
        return b[7:6] != 2'b11;
    endfunction

    function automatic field_t modrm_reg(byte_t b);
        return b[5:3];
    endfunction

endpackage

// File: rtl/lockchk_classify.sv
`timescale 1ns/1ps
module lockchk_classify
    import lockchk_pkg::*;
(
    input  byte_t       byte_in,
    output class_info_t prim_info,
    output class_info_t esc_info
);
    always_comb begin
        prim_info = primary_class(byte_in);
        esc_info  = escape_class(byte_in);
    end
endmodule

// File: rtl/lockchk_verdict.sv
`timescale 1ns/1ps
module lockchk_verdict (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic ok,
    output logic done,
    output logic legal,
    output logic illegal_op
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            legal      <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            done       <= fire;
            legal      <= fire & ok;
            illegal_op <= fire & ~ok;
        end
    end
endmodule

// File: rtl/lock_prefix_checker.sv
`timescale 1ns/1ps
module lock_prefix_checker
    import lockchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output logic             done,
    output logic             legal,
    output logic             illegal_op,
    output logic             lock_active
);
    walk_state_e state_q, state_d;
    grp_kind_e   kind_q, kind_d;
    class_info_t prim_info, esc_info;
    logic        fire, ok;

    lockchk_classify i_classify (
        .byte_in   (byte_in),
        .prim_info (prim_info),
        .esc_info  (esc_info)
    );

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        fire    = 1'b0;
        ok      = 1'b0;
        if (start) begin
            state_d = ST_FIRST;
        end else if (byte_valid) begin
            case (state_q)
                ST_FIRST: state_d = (byte_in == LOCK_BYTE) ? ST_OPC : ST_IDLE;
                ST_OPC: begin
                    case (prim_info.cls)
                        CLS_PREFIX: state_d = ST_OPC;
                        CLS_MEMOP:  state_d = ST_MOD;
                        CLS_ESCAPE: state_d = ST_ESC;
                        CLS_GROUP: begin
                            state_d = ST_GRP;
                            kind_d  = prim_info.kind;
                        end
                        default: begin
                            fire    = 1'b1;
                            state_d = ST_IDLE;
                        end
                    endcase
                end
                ST_ESC: begin
                    case (esc_info.cls)
                        CLS_MEMOP: state_d = ST_MOD;
                        CLS_GROUP: begin
                            state_d = ST_GRP;
                            kind_d  = esc_info.kind;
                        end
                        default: begin
                            fire    = 1'b1;
                            state_d = ST_IDLE;
                        end
                    endcase
                end
                ST_MOD: begin
                    fire    = 1'b1;
                    ok      = mod_is_mem(byte_in);
                    state_d = ST_IDLE;
                end
                ST_GRP: begin
                    fire    = 1'b1;
                    ok      = group_allows(kind_q, modrm_reg(byte_in)) && mod_is_mem(byte_in);
                    state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= GRP_ALU;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    assign lock_active = (state_q == ST_OPC) || (state_q == ST_ESC) ||
                         (state_q == ST_MOD) || (state_q == ST_GRP);

    lockchk_verdict i_verdict (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .ok         (ok),
        .done       (done),
        .legal      (legal),
        .illegal_op (illegal_op)
    );
endmodule

// File: rtl/lockchk_checker.sv
`timescale 1ns/1ps
module lockchk_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic byte_valid,
    input logic done,
    input logic legal,
    input logic illegal_op,
    input logic lock_active
);
    a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
        done |-> (legal ^ illegal_op));

    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!legal && !illegal_op));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r2_drop_on_verdict: assert property (@(posedge clk) disable iff (rst)
        done |-> !lock_active);

    a_r2_verdict_needs_lock: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(lock_active && byte_valid && !start));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> !lock_active);

    a_r11_no_byte_no_change: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && !start) |=> (!done && $stable(lock_active)));
endmodule

bind lock_prefix_checker lockchk_checker i_lockchk_checker (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .byte_valid  (byte_valid),
    .done        (done),
    .legal       (legal),
    .illegal_op  (illegal_op),
    .lock_active (lock_active)
);

// File: tb/test_lock_prefix_checker.sv
`timescale 1ns/1ps
module test_lock_prefix_checker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       done, legal, illegal_op, lock_active;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] seq [8];
    int         seq_n;

    always #2.5 clk = ~clk;

    lock_prefix_checker i_lock_prefix_checker (
        .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
        .byte_in(byte_in), .done(done), .legal(legal),
        .illegal_op(illegal_op), .lock_active(lock_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic bit pfx(logic [7:0] b);
        return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67};
    endfunction

    function automatic bit memb(logic [7:0] b);
        return b[7:6] != 2'b11;
    endfunction

    // Reference walk over seq[0..seq_n-1]: index of deciding byte (-1 none) and verdict
    function automatic void model(output int at, output bit ok);
        int i;
        logic [7:0] op, s;
        logic [2:0] r;
        at = -1;
        ok = 1'b0;
        if (seq_n == 0 || seq[0] != 8'hF0) return;
        i = 1;
        while (i < seq_n && pfx(seq[i])) i++;
        if (i >= seq_n) return;
        op = seq[i];
        if (op == 8'h0F) begin
            if (i + 1 >= seq_n) return;
            s = seq[i+1];
            if (s inside {8'hAB, 8'hB3, 8'hBB, 8'hB0, 8'hB1, 8'hC0, 8'hC1}) begin
                if (i + 2 >= seq_n) return;
                at = i + 2; ok = memb(seq[i+2]);
            end else if (s == 8'hBA) begin
                if (i + 2 >= seq_n) return;
                r = seq[i+2][5:3];
                at = i + 2; ok = (r >= 3'd5) && memb(seq[i+2]);
            end else begin
                at = i + 1; ok = 1'b0;
            end
            return;
        end
        if ((op < 8'h38 && op[2:0] < 3'd6) || op == 8'h86 || op == 8'h87) begin
            if (i + 1 >= seq_n) return;
            at = i + 1; ok = memb(seq[i+1]);
            return;
        end
        if (op inside {[8'h80:8'h83], 8'hF6, 8'hF7, 8'hFE, 8'hFF}) begin
            if (i + 1 >= seq_n) return;
            r = seq[i+1][5:3];
            at = i + 1;
            if (op <= 8'h83)      ok = (r != 3'd7);
            else if (op <= 8'hF7) ok = (r == 3'd2 || r == 3'd3);
            else                  ok = (r <= 3'd1);
            ok = ok && memb(seq[i+1]);
            return;
        end
        at = i; ok = 1'b0;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in = ~b;
    endtask

    // Start, stream seq, check done/verdict/lock flag at every byte
    task automatic run_seq(input string req);
        int at;
        bit ok;
        model(at, ok);
        pulse_start();
        for (int i = 0; i < seq_n; i++) begin
            send_byte(seq[i]);
            check({req, " done"}, done, (i == at));
            if (i == at) begin
                check({req, " legal"}, legal, ok);
                check({req, " illegal_op"}, illegal_op, !ok);
                check({req, " R2 lock drop"}, lock_active, 1'b0);
            end else if (i == 0) begin
                check({req, " R2 lock set"}, lock_active, (seq[0] == 8'hF0));
            end
        end
    endtask

    task automatic set3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        seq[0] = a; seq[1] = b; seq[2] = c; seq_n = 3;
    endtask

    task automatic set4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
        seq[0] = a; seq[1] = b; seq[2] = c; seq[3] = d; seq_n = 4;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] pool [12];
        logic [7:0] plist [8];
        logic [7:0] esc_pool [8];
        void'($urandom(32'd2024));
        pool = '{8'h00, 8'h09, 8'h31, 8'h87, 8'h80, 8'h83, 8'hF6, 8'hFF, 8'h0F, 8'h3B, 8'h90, 8'h45};
        plist = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67};
        esc_pool = '{8'hAB, 8'hB3, 8'hBB, 8'hB0, 8'hB1, 8'hC1, 8'hBA, 8'hA3};

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", done, 1'b0);
        check("R1 legal", legal, 1'b0);
        check("R1 illegal_op", illegal_op, 1'b0);
        check("R1 lock_active", lock_active, 1'b0);
        rst = 1'b0;

        // R4: memory-operand ADD legal, register form illegal
        set3(8'hF0, 8'h00, 8'h05); run_seq("R4 add mem");
        set3(8'hF0, 8'h00, 8'hC0); run_seq("R4 add reg");
        set3(8'hF0, 8'h87, 8'h16); run_seq("R4 xchg mem");
        // R5: never-legal opcodes
        set3(8'hF0, 8'h40, 8'h05); run_seq("R5 0x40");
        set3(8'hF0, 8'h7F, 8'h05); run_seq("R5 0x7F");
        set3(8'hF0, 8'h3A, 8'h05); run_seq("R5 cmp row");
        set3(8'hF0, 8'hF0, 8'h05); run_seq("R5 double lock");
        // R6: prefixes after LOCK
        set4(8'hF0, 8'h2E, 8'h00, 8'h05); run_seq("R6 seg prefix");
        set4(8'hF0, 8'h66, 8'h67, 8'h01); seq[4] = 8'h18; seq_n = 5; run_seq("R6 size prefixes");
        set4(8'hF0, 8'h64, 8'h01, 8'hD8); run_seq("R6 prefix reg form");
        // R7 / R8: groups
        set3(8'hF0, 8'h80, 8'h30); run_seq("R7 reg6");
        set3(8'hF0, 8'h83, 8'h38); run_seq("R7 reg7");
        set3(8'hF0, 8'hF6, 8'h18); run_seq("R8 neg");
        set3(8'hF0, 8'hF7, 8'h00); run_seq("R8 test");
        set3(8'hF0, 8'hFF, 8'h08); run_seq("R8 dec");
        set3(8'hF0, 8'hFF, 8'h10); run_seq("R8 call");
        set3(8'hF0, 8'hFE, 8'hC0); run_seq("R8 inc reg");
        // R9 / R10: escape
        set4(8'hF0, 8'h0F, 8'hB1, 8'h0E); run_seq("R9 cmpxchg mem");
        set4(8'hF0, 8'h0F, 8'hC1, 8'hC1); run_seq("R9 xadd reg");
        set4(8'hF0, 8'h0F, 8'h05, 8'h00); run_seq("R9 other escape");
        set4(8'hF0, 8'h0F, 8'hBA, 8'h28); run_seq("R10 bts imm");
        set4(8'hF0, 8'h0F, 8'hBA, 8'h20); run_seq("R10 bt imm");
        set4(8'hF0, 8'h0F, 8'hBA, 8'hF8); run_seq("R10 btc reg");
        // R2: no lock, no verdict
        set3(8'h00, 8'h05, 8'h40); run_seq("R2 no lock");

        // R11: invalid cycles ignored, start abandons a walk
        pulse_start();
        send_byte(8'hF0);
        @(negedge clk); byte_in = 8'h40;
        repeat (3) @(negedge clk);
        check("R11 hold lock", lock_active, 1'b1);
        check("R11 no verdict", done, 1'b0);
        send_byte(8'h00);
        send_byte(8'h05);
        check("R11 verdict after gap", legal, 1'b1);
        pulse_start();
        send_byte(8'hF0);
        send_byte(8'h0F);
        pulse_start();
        check("R11 start clears lock", lock_active, 1'b0);
        send_byte(8'h00);
        send_byte(8'hC0);
        check("R11 abandoned walk", done, 1'b0);

        // Random sequences (R3..R10)
        for (int t = 0; t < 400; t++) begin
            int k;
            int p;
            k = 0;
            seq[k++] = ($urandom % 10 == 0) ? 8'($urandom) : 8'hF0;
            p = $urandom % 3;
            for (int j = 0; j < p; j++) seq[k++] = plist[$urandom % 8];
            seq[k++] = ($urandom % 2) ? pool[$urandom % 12] : 8'($urandom);
            if (seq[k-1] == 8'h0F && ($urandom % 4 != 0)) seq[k++] = esc_pool[$urandom % 8];
            while (k < 8) seq[k++] = 8'($urandom);
            seq_n = 8;
            run_seq("R3 random");
        end

        finish_run();
    end
endmodule